// File: doc/BRIEF.md
# Microprogram Sequencer with Format Bit

This block is the sequencing core of a microprogrammed control unit. It keeps a control address register that selects one word of a 64-entry control memory. It loads the selected word into a control buffer register and works out the control address that comes next. The top bit of every microword picks its format. A control word puts its control field on the outputs and then moves to the next address in sequence. A branch word tests one condition, taken from the ALU flags or from an interrupt-pending input, and either jumps or falls through to the next address. A mapping branch dispatches to the routine of the current machine opcode.

The block runs on two named states. `PH_FETCH` loads the buffer from control memory and always moves to `PH_EXEC`. `PH_EXEC` drives the outputs and loads the next control address, and always moves back to `PH_FETCH`. Each microinstruction therefore takes two clocks. The control memory contents are built in and form a small microprogram. It has an instruction fetch routine at 0, an indirect routine at 8, an interrupt routine at 16, an opcode dispatch table at 32 to 47, and two execute routines at 48 and 52.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low and after its release, the control address (`uaddr`) is 0, the state is `PH_FETCH`, and `ctrl_sig` is 0.
- R2: States alternate `PH_FETCH`, `PH_EXEC`, `PH_FETCH`, and so on. `ctrl_sig` is zero in `PH_FETCH`. In `PH_EXEC` it carries bits 14:0 of the buffered word when bit 15 of that word is 0, and it is zero when bit 15 is 1. The control address changes only on the `PH_EXEC` to `PH_FETCH` transition.
- R3: After a control word (bit 15 = 0), the next control address is the current address plus 1, modulo 64.
- R4: A branch word has bit 15 = 1, condition select in bits 14:12, branch kind in bits 11:10 and target address in bits 5:0. For kind 1 (jump), a true condition loads the target.
- R5: Condition select codes are: 0 always true, 1 `flag_z`, 2 `flag_n`, 3 `flag_c`, 4 `irq_pend`, and 5 to 7 never true. The inputs are sampled at the end of `PH_EXEC`.
- R6: A branch whose condition is false goes to the current address plus 1. Kinds 0 and 3 always go to the current address plus 1.
- R7: For kind 2 (map), a true condition loads 32 + `opcode`.
- R8: The fetch routine at 0 to 2 issues signals 0x0001, 0x0006 and 0x0008. At 3 it jumps to 16 on `irq_pend`, and at 4 it maps. The interrupt routine issues 0x0100 and 0x0600, then jumps to 0. Slot 32+k, for k from 0 to 7, jumps to 48 under condition code k. Slot 40 jumps to the indirect routine: 0x0030, 0x0040, then a jump to 52. Slots 41 to 47 jump to 52. The routine at 48 issues 0x1000 and 0x2000, then jumps to 0. The routine at 52 issues 0x0800, jumps to 48 on carry, and otherwise jumps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Opcode of the current machine instruction, used by map branches |
| flag_z | input | 1 | ALU zero flag |
| flag_n | input | 1 | ALU negative flag |
| flag_c | input | 1 | ALU carry flag |
| irq_pend | input | 1 | Interrupt pending |
| ctrl_sig | output | 15 | Control signals of the executing control word |
| uaddr | output | 6 | Current control address |

## Verification
The assertions check these rules on every cycle:
- The two states alternate.
- The control address holds through `PH_FETCH`.
- A control word is followed by its address plus one.
- Unconditional jump and map branches land on the target and on 32 + opcode.
- `ctrl_sig` is never nonzero outside a control word in `PH_EXEC`.

Only the bench's scenarios can show the following:
- The condition codes pick the right flag, and codes 5 to 7 never branch.
- Untaken branches fall through.
- The built-in microprogram walks the fetch, interrupt, indirect and execute routines in the stated order for each opcode and flag pattern.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UW_W  = 16;
    localparam int CTL_W = 15;

    typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

    typedef enum logic [1:0] {
        BK_NEXT = 2'd0,
        BK_JUMP = 2'd1,
        BK_MAP  = 2'd2,
        BK_RSVD = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic irq;
    } cond_in_t;

    function automatic logic [UW_W-1:0] mk_ctl(input logic [CTL_W-1:0] sig);
        return {1'b0, sig};
    endfunction

    function automatic logic [UW_W-1:0] mk_br(input logic [2:0] sel,
                                              input br_kind_e   kind,
                                              input logic [5:0] tgt);
        return {1'b1, sel, kind, 4'b0000, tgt};
    endfunction

    // Built-in microprogram: fetch at 0, indirect at 8, interrupt at 16,
    // opcode dispatch at 32..47, execute routines at 48 and 52.
    function automatic logic [UW_W-1:0] ucode_word(input int unsigned a);
        logic [UW_W-1:0] w;
        w = '0;
        if (a >= 32 && a <= 39) begin
            w = mk_br(3'(a - 32), BK_JUMP, 6'd48);
        end else if (a >= 41 && a <= 47) begin
            w = mk_br(3'd0, BK_JUMP, 6'd52);
        end else begin
            case (a)
                0:  w = mk_ctl(15'h0001);
                1:  w = mk_ctl(15'h0006);
                2:  w = mk_ctl(15'h0008);
                3:  w = mk_br(3'd4, BK_JUMP, 6'd16);
                4:  w = mk_br(3'd0, BK_MAP, 6'd0);
                8:  w = mk_ctl(15'h0030);
                9:  w = mk_ctl(15'h0040);
                10: w = mk_br(3'd0, BK_JUMP, 6'd52);
                16: w = mk_ctl(15'h0100);
                17: w = mk_ctl(15'h0600);
                18: w = mk_br(3'd0, BK_JUMP, 6'd0);
                40: w = mk_br(3'd0, BK_JUMP, 6'd8);
                48: w = mk_ctl(15'h1000);
                49: w = mk_ctl(15'h2000);
                50: w = mk_br(3'd0, BK_JUMP, 6'd0);
                52: w = mk_ctl(15'h0800);
                53: w = mk_br(3'd3, BK_JUMP, 6'd48);
                54: w = mk_br(3'd0, BK_JUMP, 6'd0);
                default: w = '0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_cmem.sv
module useq_cmem
    import useq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    output logic [UW_W-1:0]   cbr_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [UW_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = ucode_word(g);
    end

    // Buffer register: the one-clock control memory read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cbr_q <= '0;
        end else if (load) begin
            cbr_q <= rom[addr];
        end
    end
endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
    import useq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int OPC_W    = 4,
    parameter int MAP_BASE = 32
) (
    input  logic [ADDR_W-1:0] car,
    input  logic              is_branch,
    input  logic [2:0]        sel,
    input  br_kind_e          kind,
    input  logic [ADDR_W-1:0] target,
    input  logic [OPC_W-1:0]  opcode,
    input  cond_in_t          cond,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] MAP_A = ADDR_W'(MAP_BASE);

    logic              cond_ok;
    logic [ADDR_W-1:0] inc_addr;
    logic [ADDR_W-1:0] map_addr;

    always_comb begin
        case (sel)
            3'd0:    cond_ok = 1'b1;
            3'd1:    cond_ok = cond.z;
            3'd2:    cond_ok = cond.n;
            3'd3:    cond_ok = cond.c;
            3'd4:    cond_ok = cond.irq;
            default: cond_ok = 1'b0;
        endcase
    end

    assign inc_addr = car + 1'b1;
    assign map_addr = MAP_A + {{(ADDR_W-OPC_W){1'b0}}, opcode};

    always_comb begin
        nxt = inc_addr;
        if (is_branch) begin
            unique case (kind)
                BK_JUMP: if (cond_ok) nxt = target;
                BK_MAP:  if (cond_ok) nxt = map_addr;
                BK_NEXT: nxt = inc_addr;
                BK_RSVD: nxt = inc_addr;
            endcase
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int OPC_W    = 4,
    parameter int MAP_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_c,
    input  logic              irq_pend,
    output logic [CTL_W-1:0]  ctrl_sig,
    output logic [ADDR_W-1:0] uaddr
);
    phase_e            ph_q;
    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] nxt;
    logic [UW_W-1:0]   cbr_q;
    logic              in_exec;
    cond_in_t          cond;

    assign cond    = '{z: flag_z, n: flag_n, c: flag_c, irq: irq_pend};
    assign in_exec = (ph_q == PH_EXEC);

    useq_cmem #(.ADDR_W(ADDR_W)) cmem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ph_q == PH_FETCH),
        .addr  (car_q),
        .cbr_q (cbr_q)
    );

    useq_nextsel #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_BASE(MAP_BASE)) nsel_i (
        .car       (car_q),
        .is_branch (cbr_q[UW_W-1]),
        .sel       (cbr_q[14:12]),
        .kind      (br_kind_e'(cbr_q[11:10])),
        .target    (cbr_q[ADDR_W-1:0]),
        .opcode    (opcode),
        .cond      (cond),
        .nxt       (nxt)
    );

    // State register and control address register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_FETCH;
            car_q <= '0;
        end else begin
            unique case (ph_q)
                PH_FETCH: ph_q <= PH_EXEC;
                PH_EXEC: begin
                    ph_q  <= PH_FETCH;
                    car_q <= nxt;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ctrl_sig = '0;
        unique case (ph_q)
            PH_FETCH: ctrl_sig = '0;
            PH_EXEC:  if (!cbr_q[UW_W-1]) ctrl_sig = cbr_q[CTL_W-1:0];
        endcase
    end

    assign uaddr = car_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int OPC_W    = 4,
    parameter int MAP_BASE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_exec,
    input logic [ADDR_W-1:0] car,
    input logic [UW_W-1:0]   cbr,
    input logic [OPC_W-1:0]  opcode,
    input logic [CTL_W-1:0]  ctrl_sig
);
    assert_exec_follows_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |=> in_exec);

    assert_fetch_follows_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec |=> !in_exec);

    assert_addr_hold_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |=> $stable(car));

    assert_ctrl_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sig != '0) |-> (in_exec && !cbr[UW_W-1]));

    assert_ctl_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !cbr[UW_W-1]) |=> car == ADDR_W'($past(car) + 1'b1));

    assert_always_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && cbr[UW_W-1] && cbr[14:12] == 3'd0 && cbr[11:10] == 2'd1)
        |=> car == $past(cbr[ADDR_W-1:0]));

    assert_always_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && cbr[UW_W-1] && cbr[14:12] == 3'd0 && cbr[11:10] == 2'd2)
        |=> car == ADDR_W'(MAP_BASE + int'($past(opcode))));
endmodule

bind useq_top useq_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_BASE(MAP_BASE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_exec  (in_exec),
    .car      (car_q),
    .cbr      (cbr_q),
    .opcode   (opcode),
    .ctrl_sig (ctrl_sig)
);

// File: tb/useq_tb.sv
`timescale 1ns/1ps
module useq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic        flag_z = 1'b0, flag_n = 1'b0, flag_c = 1'b0, irq_pend = 1'b0;
    logic [14:0] ctrl_sig;
    logic [5:0]  uaddr;

    always #2.5 clk = ~clk;

    useq_top dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .irq_pend(irq_pend),
        .ctrl_sig(ctrl_sig), .uaddr(uaddr)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [14:0] c;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    bit         exec_ph = 1'b1;
    logic [5:0] m_addr = '0;
    string      cur_tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference microprogram, written from requirement R8.
    function automatic logic [15:0] ref_word(input logic [5:0] a);
        logic [15:0] br1 = 16'h8000;
        case (a)
            6'd0: return 16'h0001;
            6'd1: return 16'h0006;
            6'd2: return 16'h0008;
            6'd3: return br1 | (16'd4 << 12) | (16'd1 << 10) | 16'd16;
            6'd4: return br1 | (16'd2 << 10);
            6'd8: return 16'h0030;
            6'd9: return 16'h0040;
            6'd10, 6'd41, 6'd42, 6'd43, 6'd44, 6'd45, 6'd46, 6'd47:
                  return br1 | (16'd1 << 10) | 16'd52;
            6'd16: return 16'h0100;
            6'd17: return 16'h0600;
            6'd18, 6'd50, 6'd54: return br1 | (16'd1 << 10);
            6'd40: return br1 | (16'd1 << 10) | 16'd8;
            6'd48: return 16'h1000;
            6'd49: return 16'h2000;
            6'd52: return 16'h0800;
            6'd53: return br1 | (16'd3 << 12) | (16'd1 << 10) | 16'd48;
            default:
                if (a >= 6'd32 && a <= 6'd39)
                    return br1 | (16'(a - 6'd32) << 12) | (16'd1 << 10) | 16'd48;
                else
                    return 16'h0000;
        endcase
    endfunction

    // Reference next address from R3..R7.
    function automatic logic [5:0] ref_next(input logic [5:0] a, input logic [15:0] w);
        bit ok;
        if (!w[15]) return a + 6'd1;
        case (w[14:12])
            3'd0: ok = 1;
            3'd1: ok = flag_z;
            3'd2: ok = flag_n;
            3'd3: ok = flag_c;
            3'd4: ok = irq_pend;
            default: ok = 0;
        endcase
        if (w[11:10] == 2'd1 && ok) return w[5:0];
        if (w[11:10] == 2'd2 && ok) return 6'd32 + {2'b00, opcode};
        return a + 6'd1;
    endfunction

    // Driver: called at a fetch-phase point; runs one machine instruction.
    task automatic run_instr(input string tag, input logic [3:0] op,
                             input bit z, input bit n, input bit c, input bit irq);
        int steps = 0;
        opcode = op; flag_z = z; flag_n = n; flag_c = c; irq_pend = irq;
        cur_tag = tag;
        do begin
            logic [15:0] w;
            exp_t e;
            w = ref_word(m_addr);
            e.a = m_addr;
            e.c = w[15] ? 15'd0 : w[14:0];
            sb_q.push_back(e);
            m_addr = ref_next(m_addr, w);
            steps++;
        end while (m_addr != 6'd0 && steps < 40);
        repeat (2 * steps) @(negedge clk);
    endtask

    // Monitor.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exec_ph) begin
                if (sb_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected microinstruction", int'(uaddr), 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(uaddr == e.a, cur_tag, "control address (R3 R4 R6 R7 R8)",
                        int'(uaddr), int'(e.a));
                    chk(ctrl_sig == e.c, cur_tag, "ctrl_sig in execute (R2 R8)",
                        int'(ctrl_sig), int'(e.c));
                end
            end else begin
                chk(ctrl_sig == 15'd0, "R2", "ctrl_sig in fetch", int'(ctrl_sig), 0);
            end
            exec_ph = !exec_ph;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(uaddr == 6'd0, "R1", "uaddr in reset", int'(uaddr), 0);
        chk(ctrl_sig == 15'd0, "R1", "ctrl_sig in reset", int'(ctrl_sig), 0);
        #1 rst_n = 1'b1;
        run_instr("R1_R7_always", 4'd0, 0, 0, 0, 0);
        run_instr("R5_zero_taken", 4'd1, 1, 0, 0, 0);
        run_instr("R6_fallthrough", 4'd1, 0, 0, 0, 0);
        run_instr("R5_neg_taken", 4'd2, 0, 1, 0, 0);
        run_instr("R5_carry_taken", 4'd3, 0, 0, 1, 0);
        run_instr("R5_irq_route", 4'd5, 0, 0, 0, 1);
        run_instr("R5_never_code", 4'd6, 1, 1, 0, 0);
        run_instr("R8_exec52_carry", 4'd9, 0, 0, 1, 0);
        run_instr("R7_map_op15", 4'd15, 0, 0, 0, 0);
        run_instr("R4_indirect_op8", 4'd8, 1, 1, 1, 0);
        chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule